// File: doc/BRIEF.md
# Serial ADC Host Read Controller

This block sits on the host side of a three-wire link to a 10-bit successive-approximation converter. A one-cycle `start` pulse makes it pull the active-low select line down, which starts a conversion in the converter. While the converter works, the block keeps the serial clock low and watches the data line. The converter signals the end of conversion by driving that line high. When the block sees this, it runs the serial clock and samples the line on each rising edge. The first bit it samples is the high marker itself, and it discards it. The next ten bits are the result, most significant bit first. The block then releases the select line and presents the word on a parallel output with a one-cycle strobe.

The serial clock comes from the system clock through a run-time half-period setting. The returned data line is synchronised through a short flop chain, so the half period has a floor that keeps every sample inside a settled bit. If no marker appears within a programmable number of cycles, the read is abandoned, the select line goes high and an error strobe fires. Between transactions the select line stays high for a programmable minimum time, which gives the converter room to reacquire its input.

Top module: `adc_rd_ctrl`

## Requirements
- R1: After reset `adc_cs_n` is 1, and `adc_sclk`, `result_valid`, `timeout_err` and `busy` are all 0.
- R2: A `start` pulse seen while the block is idle drives `adc_cs_n` low and `busy` high from the next clock cycle.
- R3: `adc_sclk` is 0 whenever `adc_cs_n` is 1, and stays 0 while the block waits for the end-of-conversion marker.
- R4: Values on `adc_dout` captured before `adc_cs_n` fell are never taken as the marker. With the line held high while select is high, no serial clock edge appears before the converter drives its marker.
- R5: Each read makes exactly 11 rising serial clock edges. The bit sampled on the first edge (the marker) is dropped. The bits sampled on edges 2 to 11 form `result[9:0]`, with the first of them in bit 9.
- R6: The serial clock stays high and low for max(`cfg_half`, SYNC_STAGES+1) system clock cycles each (3 with default parameters). A setting of 0, 1 or 2 therefore gives 3.
- R7: After the falling serial edge that follows the 11th rising edge, `adc_cs_n` rises. In that same cycle `result_valid` is 1 for exactly one cycle. `result` changes only in a cycle where `result_valid` is 1.
- R8: If no marker is accepted, `adc_cs_n` stays low for exactly `cfg_timeout`+1 cycles and then rises. `timeout_err` pulses for one cycle, no serial clock edge occurs, `result_valid` stays 0, and `result` keeps its previous value.
- R9: Between the rise of `adc_cs_n` and its next fall there are at least `cfg_gap` cycles. With `start` held high, the gap is `cfg_gap`+1 cycles.
- R10: A `start` seen while `busy` is 1 has no effect and does not queue another read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Request one conversion; acted on only when idle |
| cfg_half | input | HALF_W (8) | Serial clock half period in system cycles (floor SYNC_STAGES+1) |
| cfg_timeout | input | TMO_W (16) | Cycles allowed for the marker before abort |
| cfg_gap | input | GAP_W (12) | Minimum select-high cycles between reads |
| adc_dout | input | 1 | Serial data from the converter |
| adc_cs_n | output | 1 | Active-low select / conversion start |
| adc_sclk | output | 1 | Serial clock to the converter |
| result | output | DATA_W (10) | Last converted word |
| result_valid | output | 1 | One-cycle strobe when `result` is updated |
| timeout_err | output | 1 | One-cycle strobe on marker timeout |
| busy | output | 1 | High from accepted start until the gap ends |

## Verification
A sequencer stuck in the wrong state shows up within one serial clock period. Either serial clock edges appear while select is high, or a read never ends and neither strobe fires. An off-by-one in the bit counter changes the number of rising edges per select-low window. It also shifts the returned word by one position, which a known pattern such as 0x200 or 0x001 exposes on the first read. Broken masking of stale synchronizer samples makes the clock start within three cycles of select falling, before the converter has produced its marker. Counter errors in the timeout or gap logic change a select-low or select-high run length by a measurable number of cycles in the transaction where they occur.

// File: rtl/adc_rd_pkg.sv
// Shared types for the serial ADC read controller.
package adc_rd_pkg;

    // Sequencer states: idle, wait for marker, shift bits, enforced select-high gap.
    typedef enum logic [1:0] {
        RD_IDLE = 2'd0,
        RD_WAIT = 2'd1,
        RD_XFER = 2'd2,
        RD_GAP  = 2'd3
    } rd_state_e;

endpackage

// File: rtl/adc_rd_sync.sv
// Flop chain that brings the converter's data line into the system clock domain.
// Assumes: STAGES >= 1; the output lags the input by STAGES cycles.
module adc_rd_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_one
            // Single register stage.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= d;
            end
        end else begin : g_many
            // Shift the sample along the chain.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], d};
            end
        end
    endgenerate

    assign q = chain[STAGES-1];

endmodule

// File: rtl/adc_rd_sclk_gen.sv
// Serial clock generator. Toggles adc_sclk every effective half period while run
// is high and holds it low with the counter cleared otherwise. It flags, one
// cycle ahead, the edge at which the clock will rise or fall.
// Assumes: cfg_half below MIN_HALF is raised to MIN_HALF.
module adc_rd_sclk_gen #(
    parameter int HALF_W   = 8,
    parameter int MIN_HALF = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic [HALF_W-1:0] cfg_half,
    output logic              sclk,
    output logic              rise_evt,
    output logic              fall_evt
);

    localparam logic [HALF_W-1:0] MIN_L = HALF_W'(MIN_HALF);

    logic [HALF_W-1:0] half_eff;
    logic [HALF_W-1:0] cnt;
    logic              last;

    // Clamp the half period and detect its final cycle.
    always_comb begin
        half_eff = (cfg_half < MIN_L) ? MIN_L : cfg_half;
        last     = (cnt == half_eff - 1'b1);
        rise_evt = run && last && !sclk;
        fall_evt = run && last && sclk;
    end

    // Half-period counter and clock toggle.
    always_ff @(posedge clk) begin
        if (!rst_n || !run) begin
            cnt  <= '0;
            sclk <= 1'b0;
        end else if (last) begin
            cnt  <= '0;
            sclk <= !sclk;
        end else begin
            cnt  <= cnt + 1'b1;
        end
    end

endmodule

// File: rtl/adc_rd_shift.sv
// MSB-first input shift register. Bits shifted past the top are lost, so the
// leading marker drops out once all data bits have entered.
module adc_rd_shift #(
    parameter int W = 10
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         en,
    input  logic         din,
    output logic [W-1:0] word
);

    // Clear between reads, shift one bit per sampling edge.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) word <= '0;
        else if (en)       word <= {word[W-2:0], din};
    end

endmodule

// File: rtl/adc_rd_seq.sv
// Transaction sequencer: owns chip select, marker wait with timeout, bit count
// and the select-high gap. It also produces the capture and status strobes.
// Assumes: din_sync lags the pin by SYNC_STAGES cycles, so samples from the first
// SYNC_STAGES cycles of the wait predate the select fall and are masked.
module adc_rd_seq
    import adc_rd_pkg::*;
#(
    parameter int DATA_W      = 10,
    parameter int TMO_W       = 16,
    parameter int GAP_W       = 12,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start,
    input  logic [TMO_W-1:0] cfg_timeout,
    input  logic [GAP_W-1:0] cfg_gap,
    input  logic             din_sync,
    input  logic             rise_evt,
    input  logic             fall_evt,
    output logic             run,
    output logic             shift_clr,
    output logic             capture,
    output logic             cs_n,
    output logic             valid,
    output logic             err,
    output logic             busy
);

    localparam int BITS = DATA_W + 1;
    localparam int BC_W = $clog2(BITS + 1);

    rd_state_e        state;
    logic [CNT_W-1:0] cnt;
    logic [BC_W-1:0]  bitcnt;
    logic             flag_ok;
    logic             tmo_hit;
    logic             gap_done;

    // Decode conditions from the current state and counters.
    always_comb begin
        run       = (state == RD_XFER);
        shift_clr = (state == RD_IDLE);
        busy      = (state != RD_IDLE);
        flag_ok   = (cnt >= CNT_W'(SYNC_STAGES)) && din_sync;
        tmo_hit   = (cnt == CNT_W'(cfg_timeout));
        gap_done  = ((cnt + CNT_W'(1)) >= CNT_W'(cfg_gap));
        capture   = run && fall_evt && (bitcnt == BC_W'(BITS));
    end

    // State, counters, chip select and one-cycle strobes.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state  <= RD_IDLE;
            cnt    <= '0;
            bitcnt <= '0;
            cs_n   <= 1'b1;
            valid  <= 1'b0;
            err    <= 1'b0;
        end else begin
            valid <= 1'b0;
            err   <= 1'b0;
            unique case (state)
                RD_IDLE: begin
                    cnt    <= '0;
                    bitcnt <= '0;
                    if (start) begin
                        state <= RD_WAIT;
                        cs_n  <= 1'b0;
                    end
                end
                RD_WAIT: begin
                    cnt <= cnt + 1'b1;
                    if (flag_ok) begin
                        state <= RD_XFER;
                        cnt   <= '0;
                    end else if (tmo_hit) begin
                        state <= RD_GAP;
                        cs_n  <= 1'b1;
                        err   <= 1'b1;
                        cnt   <= '0;
                    end
                end
                RD_XFER: begin
                    if (rise_evt) bitcnt <= bitcnt + 1'b1;
                    if (capture) begin
                        state <= RD_GAP;
                        cs_n  <= 1'b1;
                        valid <= 1'b1;
                        cnt   <= '0;
                    end
                end
                RD_GAP: begin
                    cnt <= cnt + 1'b1;
                    if (gap_done) state <= RD_IDLE;
                end
                default: state <= RD_IDLE;
            endcase
        end
    end

endmodule

// File: rtl/adc_rd_ctrl.sv
// Host read controller for a 10-bit serial converter: select, marker wait,
// serial clocking, parallel result with strobe, timeout and inter-read gap.
// Assumes: configuration inputs are held stable while busy is high.
module adc_rd_ctrl #(
    parameter int DATA_W      = 10,
    parameter int HALF_W      = 8,
    parameter int TMO_W       = 16,
    parameter int GAP_W       = 12,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  logic [HALF_W-1:0] cfg_half,
    input  logic [TMO_W-1:0]  cfg_timeout,
    input  logic [GAP_W-1:0]  cfg_gap,
    input  logic              adc_dout,
    output logic              adc_cs_n,
    output logic              adc_sclk,
    output logic [DATA_W-1:0] result,
    output logic              result_valid,
    output logic              timeout_err,
    output logic              busy
);

    localparam int MIN_HALF = SYNC_STAGES + 1;
    localparam int CNT_W    = (TMO_W > GAP_W) ? TMO_W : GAP_W;

    logic              din_sync;
    logic              run;
    logic              rise_evt;
    logic              fall_evt;
    logic              shift_clr;
    logic              capture;
    logic [DATA_W-1:0] word;

    adc_rd_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .d     (adc_dout),
        .q     (din_sync)
    );

    adc_rd_sclk_gen #(.HALF_W(HALF_W), .MIN_HALF(MIN_HALF)) u_sclk (
        .clk      (clk),
        .rst_n    (rst_n),
        .run      (run),
        .cfg_half (cfg_half),
        .sclk     (adc_sclk),
        .rise_evt (rise_evt),
        .fall_evt (fall_evt)
    );

    adc_rd_shift #(.W(DATA_W)) u_shift (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (shift_clr),
        .en    (rise_evt),
        .din   (din_sync),
        .word  (word)
    );

    adc_rd_seq #(
        .DATA_W      (DATA_W),
        .TMO_W       (TMO_W),
        .GAP_W       (GAP_W),
        .CNT_W       (CNT_W),
        .SYNC_STAGES (SYNC_STAGES)
    ) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .cfg_timeout (cfg_timeout),
        .cfg_gap     (cfg_gap),
        .din_sync    (din_sync),
        .rise_evt    (rise_evt),
        .fall_evt    (fall_evt),
        .run         (run),
        .shift_clr   (shift_clr),
        .capture     (capture),
        .cs_n        (adc_cs_n),
        .valid       (result_valid),
        .err         (timeout_err),
        .busy        (busy)
    );

    // Hold the last completed word; update it alongside the valid strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)       result <= '0;
        else if (capture) result <= word;
    end

endmodule

// File: rtl/adc_rd_ctrl_chk.sv
// Protocol checker for adc_rd_ctrl, attached by bind. Run-length windows are
// measured with local counters rather than deep temporal operators.
module adc_rd_ctrl_chk #(
    parameter int DATA_W      = 10,
    parameter int HALF_W      = 8,
    parameter int TMO_W       = 16,
    parameter int GAP_W       = 12,
    parameter int SYNC_STAGES = 2
) (
    input logic              clk,
    input logic              rst_n,
    input logic              start,
    input logic [HALF_W-1:0] cfg_half,
    input logic [TMO_W-1:0]  cfg_timeout,
    input logic [GAP_W-1:0]  cfg_gap,
    input logic              adc_cs_n,
    input logic              adc_sclk,
    input logic [DATA_W-1:0] result,
    input logic              result_valid,
    input logic              timeout_err,
    input logic              busy
);

    localparam int MIN_HALF = SYNC_STAGES + 1;

    logic [GAP_W:0]  hi_cs;
    logic [HALF_W:0] hi_sclk;
    logic [HALF_W:0] exp_half;

    assign exp_half = (cfg_half < HALF_W'(MIN_HALF)) ? (HALF_W+1)'(MIN_HALF)
                                                     : {1'b0, cfg_half};

    // Count select-high cycles, saturating; start saturated so reset counts as a long gap.
    always_ff @(posedge clk) begin
        if (!rst_n)              hi_cs <= '1;
        else if (!adc_cs_n)      hi_cs <= '0;
        else if (hi_cs != '1)    hi_cs <= hi_cs + 1'b1;
    end

    // Count cycles the serial clock has been high.
    always_ff @(posedge clk) begin
        if (!rst_n || !adc_sclk) hi_sclk <= '0;
        else                     hi_sclk <= hi_sclk + 1'b1;
    end

    p_cs_low_after_start_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (start && !busy) |=> (!adc_cs_n && busy));

    p_sclk_low_cs_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        adc_cs_n |-> !adc_sclk);

    p_high_time_r6: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_sclk) |-> (hi_sclk == exp_half));

    p_valid_one_cycle_r7: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |=> !result_valid);

    p_valid_with_cs_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
        result_valid |-> $rose(adc_cs_n));

    p_result_held_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !result_valid |-> $stable(result));

    p_err_one_cycle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |=> !timeout_err);

    p_err_excl_r8: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_err |-> ($rose(adc_cs_n) && !result_valid));

    p_min_gap_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(adc_cs_n) |-> (hi_cs >= (GAP_W+1)'(cfg_gap)));

endmodule

bind adc_rd_ctrl adc_rd_ctrl_chk #(
    .DATA_W      (DATA_W),
    .HALF_W      (HALF_W),
    .TMO_W       (TMO_W),
    .GAP_W       (GAP_W),
    .SYNC_STAGES (SYNC_STAGES)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .start        (start),
    .cfg_half     (cfg_half),
    .cfg_timeout  (cfg_timeout),
    .cfg_gap      (cfg_gap),
    .adc_cs_n     (adc_cs_n),
    .adc_sclk     (adc_sclk),
    .result       (result),
    .result_valid (result_valid),
    .timeout_err  (timeout_err),
    .busy         (busy)
);

// File: tb/adc_rd_ctrl_tb_top.sv
// Directed bench: a behavioural converter model plus one task per scenario.
module adc_rd_ctrl_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int GAP        = 40;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start = 1'b0;
    logic [7:0]  cfg_half = 8'd4;
    logic [15:0] cfg_timeout = 16'd1000;
    logic [11:0] cfg_gap = 12'(GAP);
    logic        adc_dout = 1'b1;
    logic        adc_cs_n;
    logic        adc_sclk;
    logic [9:0]  result;
    logic        result_valid;
    logic        timeout_err;
    logic        busy;

    int n_checks = 0;
    int n_fail   = 0;

    // Converter model state and observed statistics.
    logic [9:0] adc_word = '0;
    int  conv_delay = 20;
    int  m_wait = 0, m_bit = 0;
    bit  eoc_seen = 0;
    bit  prev_sclk = 0, prev_cs = 1;
    int  cs_low_cycles, rises, rises_pre_eoc, sclk_viol, hr, last_hr;
    int  valid_cycles, valid_cs_low, err_cycles, cs_falls, cs_high_run, last_cs_high;

    always #(CLK_PERIOD/2) clk = ~clk;

    adc_rd_ctrl dut_i (
        .clk          (clk),
        .rst_n        (rst_n),
        .start        (start),
        .cfg_half     (cfg_half),
        .cfg_timeout  (cfg_timeout),
        .cfg_gap      (cfg_gap),
        .adc_dout     (adc_dout),
        .adc_cs_n     (adc_cs_n),
        .adc_sclk     (adc_sclk),
        .result       (result),
        .result_valid (result_valid),
        .timeout_err  (timeout_err),
        .busy         (busy)
    );

    task automatic clear_stats();
        cs_low_cycles = 0; rises = 0; rises_pre_eoc = 0; sclk_viol = 0;
        last_hr = 0; valid_cycles = 0; valid_cs_low = 0; err_cycles = 0; cs_falls = 0;
    endtask

    // Observer and converter model, evaluated away from the active edge.
    initial begin
        clear_stats();
        hr = 0; cs_high_run = 0; last_cs_high = 0;
        forever begin
            @(negedge clk);
            if (!adc_cs_n) cs_low_cycles++;
            if (adc_sclk && !prev_sclk && !adc_cs_n) begin
                rises++;
                if (!eoc_seen) rises_pre_eoc++;
            end
            if (adc_sclk && adc_cs_n) sclk_viol++;
            if (adc_sclk) hr++;
            else begin
                if (prev_sclk) last_hr = hr;
                hr = 0;
            end
            if (result_valid) begin
                valid_cycles++;
                if (!adc_cs_n) valid_cs_low++;
            end
            if (timeout_err) err_cycles++;
            if (!adc_cs_n && prev_cs) begin
                cs_falls++;
                last_cs_high = cs_high_run;
            end
            if (adc_cs_n) cs_high_run++; else cs_high_run = 0;
            // Converter: line floats high (pulled up) while deselected.
            if (adc_cs_n) begin
                adc_dout = 1'b1; m_wait = 0; m_bit = 0; eoc_seen = 0;
            end else if (!eoc_seen) begin
                if (conv_delay >= 0 && m_wait >= conv_delay) begin
                    adc_dout = 1'b1; eoc_seen = 1;
                end else begin
                    adc_dout = 1'b0; m_wait++;
                end
            end else if (prev_sclk && !adc_sclk) begin
                m_bit++;
                adc_dout = (m_bit <= 10) ? adc_word[10 - m_bit] : 1'b0;
            end
            prev_sclk = adc_sclk;
            prev_cs   = adc_cs_n;
        end
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic wait_end();
        for (int i = 0; i < 20000; i++) begin
            @(negedge clk);
            if (result_valid || timeout_err) break;
        end
        for (int i = 0; i < 5000; i++) begin
            if (!busy) break;
            @(negedge clk);
        end
    endtask

    task automatic pulse_start();
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
    endtask

    task automatic test_reset();
        rst_n = 1'b0;
        repeat (5) @(negedge clk);
        check(adc_cs_n == 1'b1, "R1 cs_n", int'(adc_cs_n), 1);
        check({adc_sclk, result_valid, timeout_err, busy} == 4'b0, "R1 outputs",
              int'({adc_sclk, result_valid, timeout_err, busy}), 0);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
    endtask

    // One full read with a given word, conversion delay and half period.
    task automatic test_read(input logic [9:0] w, input int dly, input int half, input string tag);
        int eff;
        eff = (half < 3) ? 3 : half;
        adc_word = w; conv_delay = dly; cfg_half = 8'(half);
        clear_stats();
        pulse_start();
        check(!adc_cs_n && busy, {"R2 select low after start ", tag}, int'({adc_cs_n, busy}), 1);
        wait_end();
        check(result == w, {"R5 result ", tag}, int'(result), int'(w));
        check(rises == 11, {"R5 rising edges ", tag}, rises, 11);
        check(rises_pre_eoc == 0, {"R4 early clock ", tag}, rises_pre_eoc, 0);
        check(sclk_viol == 0, {"R3 clock while deselected ", tag}, sclk_viol, 0);
        check(last_hr == eff, {"R6 high time ", tag}, last_hr, eff);
        check(valid_cycles == 1 && valid_cs_low == 0, {"R7 valid pulse ", tag},
              valid_cycles * 10 + valid_cs_low, 10);
        check(err_cycles == 0, {"R8 no error ", tag}, err_cycles, 0);
    endtask

    task automatic test_timeout();
        logic [9:0] prev;
        prev = result;
        conv_delay = -1; cfg_timeout = 16'd50;
        clear_stats();
        pulse_start();
        wait_end();
        check(err_cycles == 1, "R8 error pulse", err_cycles, 1);
        check(cs_low_cycles == 51, "R8 select low cycles", cs_low_cycles, 51);
        check(rises == 0 && valid_cycles == 0, "R8 no clock no valid", rises + valid_cycles, 0);
        check(result == prev, "R8 result kept", int'(result), int'(prev));
        cfg_timeout = 16'd1000; conv_delay = 20;
    endtask

    task automatic test_gap();
        adc_word = 10'h155; conv_delay = 5; cfg_half = 8'd3;
        clear_stats();
        @(negedge clk);
        start = 1'b1;
        for (int i = 0; i < 20000 && cs_falls < 2; i++) @(negedge clk);
        start = 1'b0;
        check(last_cs_high >= GAP && last_cs_high <= GAP + 1, "R9 gap length", last_cs_high, GAP + 1);
        wait_end();
        check(result == 10'h155, "R9 second read result", int'(result), 'h155);
    endtask

    task automatic test_ignore_start();
        adc_word = 10'h0F0; conv_delay = 15; cfg_half = 8'd4;
        clear_stats();
        pulse_start();
        repeat (10) @(negedge clk);
        start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (40) @(negedge clk);
        start = 1'b1; @(negedge clk); start = 1'b0;
        for (int i = 0; i < 20000; i++) begin
            if (valid_cycles != 0) break;
            @(negedge clk);
        end
        repeat (5) @(negedge clk);
        start = 1'b1; @(negedge clk); start = 1'b0;
        repeat (GAP + 30) @(negedge clk);
        check(cs_falls == 1, "R10 extra starts ignored", cs_falls, 1);
        check(!busy && adc_cs_n, "R10 idle after read", int'({busy, adc_cs_n}), 1);
        check(result == 10'h0F0, "R10 result", int'(result), 'h0F0);
    endtask

    initial begin
        test_reset();
        test_read(10'h2A5, 20, 4, "a");
        test_read(10'h3FF, 0, 5, "b");
        test_read(10'h000, 30, 3, "c");
        test_read(10'h200, 12, 0, "d");
        test_read(10'h001, 8, 1, "e");
        test_timeout();
        test_gap();
        test_ignore_start();
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

endmodule